// File: doc/BRIEF.md
# Return-From-Interrupt State Restore

This block computes the architectural state that a processor resumes with when it executes one of its return-from-interrupt instructions. The issuing stage presents a variant code together with every saved program-counter/state pair the core keeps (standard, hypervisor, early-embedded critical, embedded critical, debug, machine-check, and the link/count pair used by a legacy service-call return) and the current machine state word. One clock later the block presents the resume address, the new state word and a single-cycle redirect pulse. The front end uses that pulse to drop the current fetch block and refetch from the new address.

Each variant picks its own saved pair and its own state mask. The restored state word's bit 63 chooses the width. When it is set, the address and state stay 64 bits wide. When it is clear, both are cut to 32 bits, and only the plain return refills the upper state half from the current state word.

The request side uses a valid-only strobe with no back-pressure. A request is taken on every clock edge where `req_valid` is high, so back-to-back requests are allowed. The result side is a registered pulse, and the consumer has to take it in the cycle it is shown.

Top module: `rfi_restore`

## Requirements
- R1: During and right after reset, `next_pc` and `next_state` are zero and `redirect` is low.
- R2: Variant codes on `req_kind`: 0 plain and 1 doubleword take the standard pair, 2 takes the hypervisor pair, 3 takes the early-embedded critical pair, 4 takes the embedded critical pair, 5 takes the debug pair, 6 takes the machine-check pair, and 7 (service-call) takes its address from `link_val` and its state from `count_val`.
- R3: Variants 0, 1 and 2 clear the state bits set in 0x783F0000. Every other bit is kept.
- R4: Variant 3 clears the state bits in 0xFFFF0000. Variants 4, 5 and 6 clear the state bits in 0x3FFF0000.
- R5: Variant 7 keeps only state bits 15..0. All other state bits become zero.
- R6: When bit 63 of the selected saved state is 1, the address and the masked state keep their full 64 bits.
- R7: When bit 63 of the selected saved state is 0, bits 63..32 of `next_pc` are zero. Bits 63..32 of `next_state` are also zero, except in the case R8 describes.
- R8: For variant 0 only, in 32-bit mode, bits 63..32 of `next_state` are copied from `cur_state`.
- R9: Bits 1..0 of `next_pc` are always zero after a restore.
- R10: A request accepted at a clock edge updates `next_pc` and `next_state` and raises `redirect` for exactly the following cycle.
- R11: Codes 8 to 15 are unused. Such a request leaves `next_pc` and `next_state` unchanged and raises no `redirect`.
- R12: The block never stalls. Requests in consecutive cycles produce consecutive redirect pulses, each carrying its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled every edge |
| req_kind | input | 4 | Variant code (R2) |
| cur_state | input | 64 | Current machine state word |
| sv_pc_std | input | 64 | Standard saved address |
| sv_st_std | input | 64 | Standard saved state |
| sv_pc_hyp | input | 64 | Hypervisor saved address |
| sv_st_hyp | input | 64 | Hypervisor saved state |
| sv_pc_early | input | 64 | Early-embedded critical saved address |
| sv_st_early | input | 64 | Early-embedded critical saved state |
| sv_pc_crit | input | 64 | Embedded critical saved address |
| sv_st_crit | input | 64 | Embedded critical saved state |
| sv_pc_dbg | input | 64 | Debug saved address |
| sv_st_dbg | input | 64 | Debug saved state |
| sv_pc_mchk | input | 64 | Machine-check saved address |
| sv_st_mchk | input | 64 | Machine-check saved state |
| link_val | input | 64 | Link value (service-call address) |
| count_val | input | 64 | Count value (service-call state) |
| next_pc | output | 64 | Resume address |
| next_state | output | 64 | Restored machine state word |
| redirect | output | 1 | One-cycle flush-and-refetch pulse |

## Verification
Every saved pair is loaded with a different address, so a check on the address shows which pair a variant read. All-ones saved states show each variant's mask as the bits that drop out. Saved states with bit 63 clear, paired with a current state that has a non-zero upper half, show whether the upper half was truncated or refilled, and only the plain variant may refill it. Unused codes, back-to-back requests and long random streams with a random mode bit are compared every cycle against a behavioural model.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  typedef enum logic [2:0] {
    RV_PLAIN = 3'd0, RV_DWORD = 3'd1, RV_HYPER = 3'd2, RV_EARLY = 3'd3,
    RV_CRIT  = 3'd4, RV_DEBUG = 3'd5, RV_MCHK  = 3'd6, RV_SVC   = 3'd7
  } rv_kind_e;

  // bank slot of each saved pair
  localparam int unsigned SLOT_STD   = 0;
  localparam int unsigned SLOT_HYP   = 1;
  localparam int unsigned SLOT_EARLY = 2;
  localparam int unsigned SLOT_CRIT  = 3;
  localparam int unsigned SLOT_DBG   = 4;
  localparam int unsigned SLOT_MCHK  = 5;
  localparam int unsigned SLOT_LINK  = 6;
  localparam int unsigned NSLOT      = 7;

  localparam logic [31:0] CLR_STD   = 32'h783F_0000;
  localparam logic [31:0] CLR_EARLY = 32'hFFFF_0000;
  localparam logic [31:0] CLR_EMB   = 32'h3FFF_0000;
  localparam int unsigned SVC_KEEP_BITS = 16;

  typedef struct packed {
    logic        known;
    logic        keep_hi;
    logic        svc;
    logic [2:0]  slot;
    logic [31:0] clr;
  } rv_ctl_t;
endpackage

// File: rtl/rfi_decode.sv
module rfi_decode
  import rfi_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] kind,
  output rv_ctl_t          ctl
);
  always_comb begin
    ctl.known   = ~|kind[SEL_W-1:3];
    ctl.keep_hi = 1'b0;
    ctl.svc     = 1'b0;
    ctl.slot    = 3'(SLOT_STD);
    ctl.clr     = CLR_STD;
    unique case (rv_kind_e'(kind[2:0]))
      RV_PLAIN: ctl.keep_hi = 1'b1;
      RV_DWORD: ;
      RV_HYPER: ctl.slot = 3'(SLOT_HYP);
      RV_EARLY: begin ctl.slot = 3'(SLOT_EARLY); ctl.clr = CLR_EARLY; end
      RV_CRIT:  begin ctl.slot = 3'(SLOT_CRIT);  ctl.clr = CLR_EMB;   end
      RV_DEBUG: begin ctl.slot = 3'(SLOT_DBG);   ctl.clr = CLR_EMB;   end
      RV_MCHK:  begin ctl.slot = 3'(SLOT_MCHK);  ctl.clr = CLR_EMB;   end
      RV_SVC:   begin ctl.slot = 3'(SLOT_LINK);  ctl.svc = 1'b1;      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rfi_pair_mux.sv
module rfi_pair_mux #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NSLOT = 7,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0][XLEN-1:0] pc_bank,
  input  logic [NSLOT-1:0][XLEN-1:0] st_bank,
  input  logic [IW-1:0]              slot,
  output logic [XLEN-1:0]            pc_sel,
  output logic [XLEN-1:0]            st_sel
);
  logic [NSLOT-1:0] hit;
  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
      assign hit[g] = (slot == IW'(g));
    end
  endgenerate

  always_comb begin
    pc_sel = '0;
    st_sel = '0;
    for (int i = 0; i < NSLOT; i++) begin
      pc_sel |= pc_bank[i] & {XLEN{hit[i]}};
      st_sel |= st_bank[i] & {XLEN{hit[i]}};
    end
  end
endmodule

// File: rtl/rfi_width_fix.sv
module rfi_width_fix #(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned KEEP_BITS = 16,
  localparam int unsigned HALF     = XLEN / 2
) (
  input  logic [XLEN-1:0] pc_raw,
  input  logic [XLEN-1:0] st_raw,
  input  logic [31:0]     clr,
  input  logic            svc,
  input  logic            keep_hi,
  input  logic [HALF-1:0] cur_hi,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] st_out
);
  logic            wide;
  logic [XLEN-1:0] and_mask;
  logic [XLEN-1:0] st_m;
  logic [XLEN-1:0] pc_t;

  assign wide = st_raw[XLEN-1];

  always_comb begin
    if (svc) and_mask = {{(XLEN-KEEP_BITS){1'b0}}, {KEEP_BITS{1'b1}}};
    else     and_mask = ~{{(XLEN-32){1'b0}}, clr};
    st_m = st_raw & and_mask;
    if (wide) begin
      st_out = st_m;
      pc_t   = pc_raw;
    end else begin
      st_out = {(keep_hi ? cur_hi : {HALF{1'b0}}), st_m[HALF-1:0]};
      pc_t   = {{HALF{1'b0}}, pc_raw[HALF-1:0]};
    end
    pc_out = {pc_t[XLEN-1:2], 2'b00};
  end
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
  import rfi_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_kind,
  input  logic [XLEN-1:0]  cur_state,
  input  logic [XLEN-1:0]  sv_pc_std,
  input  logic [XLEN-1:0]  sv_st_std,
  input  logic [XLEN-1:0]  sv_pc_hyp,
  input  logic [XLEN-1:0]  sv_st_hyp,
  input  logic [XLEN-1:0]  sv_pc_early,
  input  logic [XLEN-1:0]  sv_st_early,
  input  logic [XLEN-1:0]  sv_pc_crit,
  input  logic [XLEN-1:0]  sv_st_crit,
  input  logic [XLEN-1:0]  sv_pc_dbg,
  input  logic [XLEN-1:0]  sv_st_dbg,
  input  logic [XLEN-1:0]  sv_pc_mchk,
  input  logic [XLEN-1:0]  sv_st_mchk,
  input  logic [XLEN-1:0]  link_val,
  input  logic [XLEN-1:0]  count_val,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  next_state,
  output logic             redirect
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned IW   = $clog2(NSLOT);

  rv_ctl_t                    ctl;
  logic [NSLOT-1:0][XLEN-1:0] pc_bank, st_bank;
  logic [XLEN-1:0]            pc_sel, st_sel, pc_fix, st_fix;
  logic                       take;

  rfi_decode #(.SEL_W(SEL_W)) u_dec (.kind(req_kind), .ctl(ctl));

  always_comb begin
    pc_bank[SLOT_STD]   = sv_pc_std;    st_bank[SLOT_STD]   = sv_st_std;
    pc_bank[SLOT_HYP]   = sv_pc_hyp;    st_bank[SLOT_HYP]   = sv_st_hyp;
    pc_bank[SLOT_EARLY] = sv_pc_early;  st_bank[SLOT_EARLY] = sv_st_early;
    pc_bank[SLOT_CRIT]  = sv_pc_crit;   st_bank[SLOT_CRIT]  = sv_st_crit;
    pc_bank[SLOT_DBG]   = sv_pc_dbg;    st_bank[SLOT_DBG]   = sv_st_dbg;
    pc_bank[SLOT_MCHK]  = sv_pc_mchk;   st_bank[SLOT_MCHK]  = sv_st_mchk;
    pc_bank[SLOT_LINK]  = link_val;     st_bank[SLOT_LINK]  = count_val;
  end

  rfi_pair_mux #(.XLEN(XLEN), .NSLOT(NSLOT)) u_mux (
    .pc_bank(pc_bank), .st_bank(st_bank), .slot(IW'(ctl.slot)),
    .pc_sel(pc_sel), .st_sel(st_sel)
  );

  rfi_width_fix #(.XLEN(XLEN), .KEEP_BITS(SVC_KEEP_BITS)) u_fix (
    .pc_raw(pc_sel), .st_raw(st_sel), .clr(ctl.clr), .svc(ctl.svc),
    .keep_hi(ctl.keep_hi), .cur_hi(cur_state[XLEN-1:HALF]),
    .pc_out(pc_fix), .st_out(st_fix)
  );

  assign take = req_valid & ctl.known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc    <= '0;
      next_state <= '0;
      redirect   <= 1'b0;
    end else begin
      redirect <= take;
      if (take) begin
        next_pc    <= pc_fix;
        next_state <= st_fix;
      end
    end
  end
endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEL_W-1:0] req_kind,
  input logic [XLEN-1:0]  sv_st_std,
  input logic [XLEN-1:0]  next_pc,
  input logic [XLEN-1:0]  next_state,
  input logic             redirect
);
  logic used_code;
  assign used_code = (req_kind < SEL_W'(8));

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (next_pc[1:0] == 2'b00)); // R9

  AST_PULSE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && used_code) |=> redirect); // R10

  AST_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !used_code) |=> (!redirect && $stable(next_pc) && $stable(next_state))); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!redirect && $stable(next_pc) && $stable(next_state))); // R10

  AST_DWORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == SEL_W'(1) && !sv_st_std[XLEN-1]) |=>
      (next_pc[XLEN-1:XLEN/2] == '0 && next_state[XLEN-1:XLEN/2] == '0)); // R7
endmodule

bind rfi_restore rfi_restore_chk #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .sv_st_std(sv_st_std), .next_pc(next_pc), .next_state(next_state),
  .redirect(redirect)
);

// File: tb/tb_rfi_restore.sv
module tb_rfi_restore;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [3:0] req_kind = 0;
  logic [63:0] cur_state = 0;
  logic [63:0] pcs [7];
  logic [63:0] sts [7];
  logic [63:0] next_pc, next_state;
  logic redirect;
  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  logic [63:0] m_pc = 0, m_st = 0;
  logic m_red = 0;

  always #2.5 clk = ~clk;

  rfi_restore dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cur_state(cur_state),
    .sv_pc_std(pcs[0]), .sv_st_std(sts[0]), .sv_pc_hyp(pcs[1]), .sv_st_hyp(sts[1]),
    .sv_pc_early(pcs[2]), .sv_st_early(sts[2]), .sv_pc_crit(pcs[3]), .sv_st_crit(sts[3]),
    .sv_pc_dbg(pcs[4]), .sv_st_dbg(sts[4]), .sv_pc_mchk(pcs[5]), .sv_st_mchk(sts[5]),
    .link_val(pcs[6]), .count_val(sts[6]),
    .next_pc(next_pc), .next_state(next_state), .redirect(redirect)
  );

  function automatic int pair_of(int k);
    case (k)
      0, 1: return 0;
      2: return 1;
      3: return 2;
      4: return 3;
      5: return 4;
      6: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [63:0] keep_mask(int k);
    if (k <= 2) return ~64'h0000_0000_783F_0000;
    if (k == 3) return ~64'h0000_0000_FFFF_0000;
    if (k <= 6) return ~64'h0000_0000_3FFF_0000;
    return 64'h0000_0000_0000_FFFF;
  endfunction

  // behavioural reference, updated at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= 0; m_st <= 0; m_red <= 0;
    end else if (req_valid && req_kind < 8) begin
      automatic int k = req_kind;
      automatic logic [63:0] a = pcs[pair_of(k)];
      automatic logic [63:0] s = sts[pair_of(k)];
      automatic logic [63:0] r = s & keep_mask(k);
      if (s[63] == 1'b0) begin
        a = a % 64'h1_0000_0000;
        r = (k == 0) ? {cur_state[63:32], r[31:0]} : {32'h0, r[31:0]};
      end
      m_pc <= a - (a % 4);
      m_st <= r;
      m_red <= 1;
    end else begin
      m_red <= 0;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare with the model on every clock (R2 general behaviour)
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2", "model pc", next_pc, m_pc);
    chk("R2", "model state", next_state, m_st);
    chk("R10", "model redirect", {63'h0, redirect}, {63'h0, m_red});
  end

  task automatic issue(int k);
    @(negedge clk); req_valid = 1; req_kind = 4'(k);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic load_all(logic [63:0] st);
    for (int i = 0; i < 7; i++) begin
      pcs[i] = 64'hC000_0000_0000_0000 | (64'(i + 1) << 36) | (64'(i + 1) << 8) | 64'h3;
      sts[i] = st;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    load_all(64'h0);
    cur_state = 64'hAAAA_BBBB_0000_0000;
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", next_pc, 0);
    chk("R1", "reset state", next_state, 0);
    chk("R1", "reset redirect", {63'h0, redirect}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset redirect", {63'h0, redirect}, 0);

    // R2: each variant reads its own pair (wide mode, no state bits)
    load_all(64'h8000_0000_0000_0000);
    for (int k = 0; k < 8; k++) begin
      automatic int p = pair_of(k);
      issue(k);
      chk("R2", "pair address", next_pc,
          64'hC000_0000_0000_0000 | (64'(p + 1) << 36) | (64'(p + 1) << 8));
    end

    // masks with all-ones saved state (wide mode)
    load_all(64'hFFFF_FFFF_FFFF_FFFF);
    issue(1); chk("R3", "dword mask", next_state, 64'hFFFF_FFFF_87C0_FFFF);
    chk("R9", "low bits cleared", {62'h0, next_pc[1:0]}, 0);
    issue(2); chk("R3", "hyper mask", next_state, 64'hFFFF_FFFF_87C0_FFFF);
    issue(3); chk("R4", "early mask", next_state, 64'hFFFF_FFFF_0000_FFFF);
    issue(4); chk("R4", "crit mask", next_state, 64'hFFFF_FFFF_C000_FFFF);
    issue(5); chk("R4", "debug mask", next_state, 64'hFFFF_FFFF_C000_FFFF);
    issue(6); chk("R4", "mchk mask", next_state, 64'hFFFF_FFFF_C000_FFFF);
    issue(7); chk("R5", "svc keep", next_state, 64'h0000_0000_0000_FFFF);
    chk("R6", "svc wide pc", next_pc, 64'hC000_0070_0000_0700);

    // R6 plain wide
    sts[0] = 64'h8000_0001_FFFF_0000; pcs[0] = 64'h1234_5678_9ABC_DEF3;
    issue(0);
    chk("R6", "wide state", next_state, 64'h8000_0001_87C0_0000);
    chk("R6", "wide pc", next_pc, 64'h1234_5678_9ABC_DEF0);

    // R8 plain narrow keeps upper from current
    sts[0] = 64'h0000_0000_FFFF_FFFF;
    issue(0);
    chk("R8", "plain narrow state", next_state, 64'hAAAA_BBBB_87C0_FFFF);
    chk("R7", "plain narrow pc", next_pc, 64'h0000_0000_9ABC_DEF0);

    // R7 hyper narrow does not refill
    sts[1] = 64'h0000_0000_783F_1234; pcs[1] = 64'hFFFF_FFFF_0000_0106;
    issue(2);
    chk("R7", "hyper narrow state", next_state, 64'h0000_0000_0000_1234);
    chk("R9", "hyper narrow pc", next_pc, 64'h0000_0000_0000_0104);
    @(negedge clk);
    chk("R10", "pulse ends", {63'h0, redirect}, 0);

    // R11 unused codes
    for (int k = 8; k < 16; k++) begin
      issue(k);
      chk("R11", "no redirect", {63'h0, redirect}, 0);
      chk("R11", "state held", next_state, 64'h0000_0000_0000_1234);
      chk("R11", "pc held", next_pc, 64'h0000_0000_0000_0104);
    end

    // R12 back-to-back
    load_all(64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); req_valid = 1; req_kind = 3;
    @(negedge clk); req_kind = 7;
    chk("R12", "first result", next_state, 64'hFFFF_FFFF_0000_FFFF);
    chk("R12", "first pulse", {63'h0, redirect}, 1);
    @(negedge clk); req_valid = 0;
    chk("R12", "second result", next_state, 64'h0000_0000_0000_FFFF);
    chk("R12", "second pulse", {63'h0, redirect}, 1);

    // random stream against the model
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      req_valid = ($urandom % 4) != 0;
      req_kind  = 4'($urandom);
      cur_state = {$urandom, $urandom};
      for (int i = 0; i < 7; i++) begin
        pcs[i] = {$urandom, $urandom};
        sts[i] = {$urandom, $urandom};
      end
    end
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule